// File: doc/BRIEF.md
# T1 Transmit Overhead Error Injector

This block sits in a T1 transmit path, just before line coding. It alters the outgoing frame stream for three purposes: framing-error testing, D4 yellow alarm signalling and zero suppression of channel data. The stream is byte-serial. Each 193-bit frame arrives as one framing-bit slot, with the bit carried in data bit 0, followed by 24 channel bytes. The output stream has the same shape as the input and is delayed by exactly one clock.

A frame counter follows the superframe. It restarts on a start marker carried with the framing slot of frame 1, and it wraps after 12 frames in D4 mode or after 24 in ESF mode. The counter decides which framing bits can be corrupted: the terminal framing bits in D4 and the pattern bits in ESF. It also locates frame 12 for the S-bit form of the yellow alarm.

Framing-bit corruption has two modes. The continuous mode inverts one eligible bit in every 128. The burst mode starts on a rising edge of its control and inverts three eligible bits in a row, which is enough to make the far end lose frame alignment.

Top module: `t1_ovh_injector`

## Requirements
- R1: Every input cycle appears at the outputs exactly one clock later. `out_valid` equals the previous `in_valid`, and `out_fslot` equals the previous `in_valid && in_fslot`. On idle cycles, `out_data` is 0.
- R2: The frame number is 1 on a framing slot that carries `in_sf_start`. Otherwise it is the previous frame number plus one, wrapping to 1 after 12 (D4, `esf_mode`=0) or after 24 (ESF, `esf_mode`=1). Eligible framing bits are those of the odd frames in D4 and of the frames that are a multiple of 4 in ESF. The framing bit is carried in data bit 0, and bits 7..1 of a framing slot pass through unchanged.
- R3: While `cont_corrupt_en` is high, the first eligible framing bit at or after its rising edge is inverted. After that, every 128th eligible framing bit is inverted. The count restarts on each new rising edge.
- R4: A rising edge on `burst_corrupt_req` inverts the next three eligible framing bits, counting one that arrives in the same cycle as the edge. A new rising edge during a burst restarts the count at three. Framing slots that are not eligible are never inverted.
- R5: When the continuous mode and the burst hit the same eligible bit, that bit is inverted once, and the hit counts as one of the three burst bits.
- R6: With `yel_alarm_on`=1, `yel_s_bit_sel`=0 and D4 mode, bit 2 of every channel byte is forced to 0. Bits are numbered 1 (MSB, data[7]) to 8 (LSB, data[0]), so bit 2 is data[6]. In ESF mode the alarm leaves the stream unchanged.
- R7: With `yel_alarm_on`=1, `yel_s_bit_sel`=1 and D4 mode, the framing bit of frame 12 is sent as 1 and channel bytes are unchanged.
- R8: With `zero_sup_en`=1, a channel byte that is all zeros is sent as 8'h02, which sets bit 7 (data[1]). Other bytes pass unchanged. The test is applied after the R6 forcing, so a byte of 8'h40 under the R6 alarm is sent as 8'h02.
- R9: After reset the outputs are 0. With every control at 0, framing slots and channel bytes pass unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | A slot is presented this cycle |
| in_fslot | input | 1 | 1 = framing-bit slot, 0 = channel byte |
| in_sf_start | input | 1 | Framing slot is frame 1 of the superframe |
| in_data | input | 8 | Channel byte, or framing bit in bit 0 |
| esf_mode | input | 1 | 0 = D4 superframe, 1 = ESF |
| cont_corrupt_en | input | 1 | Continuous one-in-128 corruption |
| burst_corrupt_req | input | 1 | Rising edge starts a three-bit burst |
| yel_alarm_on | input | 1 | Send the D4 yellow alarm |
| yel_s_bit_sel | input | 1 | 0 = clear bit 2 of channels, 1 = S-bit of frame 12 |
| zero_sup_en | input | 1 | Bit-7 zero suppression |
| out_valid | output | 1 | Output slot present |
| out_fslot | output | 1 | Output slot is a framing slot |
| out_data | output | 8 | Modified slot data |

## Verification
The bench runs the continuous mode over 300 D4 frames. A counter that also counted frames that are not eligible, or that did not restart on the edge, would invert the wrong frame. A burst is restarted in the middle of its run, and a design that ignored the second edge would stop one or two bits early. The bench raises both corruption controls on the same eligible bit. A design that inverted that bit twice would send it unchanged. The last checks send byte 8'h40 under the bit-2 alarm with zero suppression on, and a design that tested for zeros before forcing would send an all-zero byte.

// File: rtl/t1ovh_pkg.sv
package t1ovh_pkg;
    localparam int T1_BYTE_W = 8;

    typedef struct packed {
        logic                 valid;
        logic                 fslot;
        logic [T1_BYTE_W-1:0] data;
    } t1_slot_t;
endpackage

// File: rtl/t1ovh_frame_pos.sv
module t1ovh_frame_pos #(
    parameter int D4_FRAMES   = 12,
    parameter int ESF_FRAMES  = 24,
    parameter int FPS_SPACING = 4,
    localparam int FW         = $clog2(ESF_FRAMES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          slot_stb,
    input  logic          sf_start,
    input  logic          esf_mode,
    output logic [FW-1:0] frame_num,
    output logic          eligible
);
    localparam logic [FW-1:0] D4_LAST  = FW'(D4_FRAMES);
    localparam logic [FW-1:0] ESF_LAST = FW'(ESF_FRAMES);
    localparam logic [FW-1:0] SPACING  = FW'(FPS_SPACING);
    localparam logic [FW-1:0] FIRST    = FW'(1);

    typedef struct packed {
        logic [FW-1:0] frame;
    } pos_t;

    pos_t          st_d, st_q;
    logic [FW-1:0] last_frame;
    logic [FW-1:0] cur_frame;

    always_comb begin
        st_d       = st_q;
        last_frame = esf_mode ? ESF_LAST : D4_LAST;
        if (sf_start || st_q.frame >= last_frame) begin
            cur_frame = FIRST;
        end else begin
            cur_frame = st_q.frame + FIRST;
        end
        if (slot_stb) begin
            st_d.frame = cur_frame;
        end
        frame_num = cur_frame;
        if (esf_mode) begin
            eligible = (cur_frame % SPACING) == '0;
        end else begin
            eligible = cur_frame[0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R2
    frame_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.frame <= ESF_LAST);

    // R2
    d4_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_stb && !sf_start && !esf_mode && st_q.frame == D4_LAST) |=> st_q.frame == FIRST);

    // R2
    sf_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_stb && sf_start) |=> st_q.frame == FIRST);
endmodule

// File: rtl/t1ovh_fb_corrupt.sv
module t1ovh_fb_corrupt #(
    parameter int CONT_PERIOD = 128,
    parameter int BURST_LEN   = 3,
    localparam int CW         = $clog2(CONT_PERIOD),
    localparam int BW         = $clog2(BURST_LEN + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic slot_stb,
    input  logic eligible,
    input  logic cont_en,
    input  logic burst_req,
    output logic flip
);
    localparam logic [CW-1:0] CNT_LAST   = CW'(CONT_PERIOD - 1);
    localparam logic [BW-1:0] BURST_INIT = BW'(BURST_LEN);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [BW-1:0] left;
        logic          cont_prev;
        logic          burst_prev;
    } cor_t;

    cor_t          st_d, st_q;
    logic          cont_rise, burst_rise;
    logic [CW-1:0] cnt_eff;
    logic [BW-1:0] left_eff;

    always_comb begin
        st_d            = st_q;
        cont_rise       = cont_en && !st_q.cont_prev;
        burst_rise      = burst_req && !st_q.burst_prev;
        cnt_eff         = cont_rise ? '0 : st_q.cnt;
        left_eff        = burst_rise ? BURST_INIT : st_q.left;
        st_d.cont_prev  = cont_en;
        st_d.burst_prev = burst_req;
        st_d.cnt        = cnt_eff;
        st_d.left       = left_eff;
        flip            = 1'b0;
        if (slot_stb && eligible) begin
            if (cont_en) begin
                if (cnt_eff == '0) begin
                    flip = 1'b1;
                end
                st_d.cnt = (cnt_eff == CNT_LAST) ? '0 : cnt_eff + 1'b1;
            end
            if (left_eff != '0) begin
                flip      = 1'b1;
                st_d.left = left_eff - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R4
    burst_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.left <= BURST_INIT);

    // R4
    burst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(slot_stb && eligible) && !(burst_req && !st_q.burst_prev)) |=> $stable(st_q.left));

    // R3
    cont_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(slot_stb && eligible) && !(cont_en && !st_q.cont_prev)) |=> $stable(st_q.cnt));
endmodule

// File: rtl/t1ovh_chan_mod.sv
module t1ovh_chan_mod
    import t1ovh_pkg::*;
#(
    parameter int YEL_BIT = 2,
    parameter int ZS_BIT  = 7
) (
    input  logic [T1_BYTE_W-1:0] byte_in,
    input  logic                 yel_clear,
    input  logic                 zs_en,
    output logic [T1_BYTE_W-1:0] byte_out
);
    localparam int YEL_IDX = T1_BYTE_W - YEL_BIT;
    localparam int ZS_IDX  = T1_BYTE_W - ZS_BIT;

    always_comb begin
        byte_out = byte_in;
        if (yel_clear) begin
            byte_out[YEL_IDX] = 1'b0;
        end
        if (zs_en && byte_out == '0) begin
            byte_out[ZS_IDX] = 1'b1;
        end
    end
endmodule

// File: rtl/t1_ovh_injector.sv
module t1_ovh_injector
    import t1ovh_pkg::*;
#(
    parameter int D4_FRAMES   = 12,
    parameter int ESF_FRAMES  = 24,
    parameter int FPS_SPACING = 4,
    parameter int CONT_PERIOD = 128,
    parameter int BURST_LEN   = 3,
    parameter int YEL_FRAME   = 12,
    parameter int YEL_BIT     = 2,
    parameter int ZS_BIT      = 7
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic                 in_fslot,
    input  logic                 in_sf_start,
    input  logic [T1_BYTE_W-1:0] in_data,
    input  logic                 esf_mode,
    input  logic                 cont_corrupt_en,
    input  logic                 burst_corrupt_req,
    input  logic                 yel_alarm_on,
    input  logic                 yel_s_bit_sel,
    input  logic                 zero_sup_en,
    output logic                 out_valid,
    output logic                 out_fslot,
    output logic [T1_BYTE_W-1:0] out_data
);
    localparam int FW                = $clog2(ESF_FRAMES + 1);
    localparam logic [FW-1:0] YEL_FN = FW'(YEL_FRAME);
    localparam int YEL_IDX           = T1_BYTE_W - YEL_BIT;

    t1_slot_t             out_d, out_q;
    logic                 slot_stb;
    logic [FW-1:0]        frame_num;
    logic                 eligible;
    logic                 flip;
    logic                 s_bit_force;
    logic [T1_BYTE_W-1:0] chan_byte;

    assign slot_stb = in_valid && in_fslot;

    t1ovh_frame_pos #(
        .D4_FRAMES  (D4_FRAMES),
        .ESF_FRAMES (ESF_FRAMES),
        .FPS_SPACING(FPS_SPACING)
    ) i_pos (
        .clk      (clk),
        .rst_n    (rst_n),
        .slot_stb (slot_stb),
        .sf_start (in_sf_start),
        .esf_mode (esf_mode),
        .frame_num(frame_num),
        .eligible (eligible)
    );

    t1ovh_fb_corrupt #(
        .CONT_PERIOD(CONT_PERIOD),
        .BURST_LEN  (BURST_LEN)
    ) i_cor (
        .clk      (clk),
        .rst_n    (rst_n),
        .slot_stb (slot_stb),
        .eligible (eligible),
        .cont_en  (cont_corrupt_en),
        .burst_req(burst_corrupt_req),
        .flip     (flip)
    );

    t1ovh_chan_mod #(
        .YEL_BIT(YEL_BIT),
        .ZS_BIT (ZS_BIT)
    ) i_chan (
        .byte_in  (in_data),
        .yel_clear(yel_alarm_on && !yel_s_bit_sel && !esf_mode),
        .zs_en    (zero_sup_en),
        .byte_out (chan_byte)
    );

    always_comb begin
        out_d       = '0;
        s_bit_force = yel_alarm_on && yel_s_bit_sel && !esf_mode && frame_num == YEL_FN;
        if (in_valid) begin
            out_d.valid = 1'b1;
            out_d.fslot = in_fslot;
            if (in_fslot) begin
                out_d.data    = in_data;
                out_d.data[0] = (in_data[0] ^ flip) | s_bit_force;
            end else begin
                out_d.data = chan_byte;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign out_valid = out_q.valid;
    assign out_fslot = out_q.fslot;
    assign out_data  = out_q.data;

    // R1
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R1
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && out_data == '0));

    // R8
    zero_sup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_fslot && zero_sup_en) |=> out_data != '0);

    // R6
    yel_bit2_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_fslot && yel_alarm_on && !yel_s_bit_sel && !esf_mode && !zero_sup_en)
        |=> !out_data[YEL_IDX]);

    // R7
    s_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_stb && s_bit_force) |=> out_data[0]);
endmodule

// File: tb/test_t1_ovh_injector.sv
module test_t1_ovh_injector;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       in_valid, in_fslot, in_sf_start;
    logic [7:0] in_data;
    logic       esf_mode, cont_corrupt_en, burst_corrupt_req;
    logic       yel_alarm_on, yel_s_bit_sel, zero_sup_en;
    logic       out_valid, out_fslot;
    logic [7:0] out_data;

    int   nchk = 0;
    int   nerr = 0;
    int   tb_frame = 0;
    int   ccnt = 0;
    int   bleft = 0;
    logic cprev = 1'b0;
    logic bprev = 1'b0;

    always #2 clk = ~clk;

    t1_ovh_injector i_t1_ovh_injector (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_fslot(in_fslot),
        .in_sf_start(in_sf_start), .in_data(in_data), .esf_mode(esf_mode),
        .cont_corrupt_en(cont_corrupt_en), .burst_corrupt_req(burst_corrupt_req),
        .yel_alarm_on(yel_alarm_on), .yel_s_bit_sel(yel_s_bit_sel),
        .zero_sup_en(zero_sup_en), .out_valid(out_valid), .out_fslot(out_fslot),
        .out_data(out_data)
    );

    // fields: [19] esf [18] yel_on [17] yel_sel [16] zs [15:8] byte in [7:0] expected
    localparam logic [19:0] VEC [10] = '{
        {4'b0000, 8'h00, 8'h00},   // R9 pass-through
        {4'b0001, 8'h00, 8'h02},   // R8
        {4'b0001, 8'h80, 8'h80},   // R8 nonzero unchanged
        {4'b0100, 8'hFF, 8'hBF},   // R6
        {4'b0101, 8'h40, 8'h02},   // R8 after R6
        {4'b1100, 8'hFF, 8'hFF},   // R6 ESF no effect
        {4'b0110, 8'hFF, 8'hFF},   // R7 bytes untouched
        {4'b0001, 8'h01, 8'h01},   // R8
        {4'b1001, 8'h00, 8'h02},   // R8 in ESF
        {4'b0100, 8'h42, 8'h02}    // R6
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input logic v, input logic fs, input logic sf, input logic [7:0] d);
        in_valid    = v;
        in_fslot    = fs;
        in_sf_start = sf;
        in_data     = d;
        @(posedge clk);
        #1;
        cprev = cont_corrupt_en;
        bprev = burst_corrupt_req;
    endtask

    task automatic fbit_slot(input logic sf, input logic fb, input string req);
        int   last;
        int   ce;
        int   be;
        logic elig;
        logic inv;
        logic expb;
        last     = esf_mode ? 24 : 12;
        tb_frame = (sf || tb_frame >= last) ? 1 : tb_frame + 1;
        elig     = esf_mode ? (tb_frame % 4 == 0) : (tb_frame % 2 == 1);
        ce       = (cont_corrupt_en && !cprev) ? 0 : ccnt;
        be       = (burst_corrupt_req && !bprev) ? 3 : bleft;
        ccnt     = ce;
        bleft    = be;
        inv      = 1'b0;
        if (elig) begin
            if (cont_corrupt_en) begin
                if (ce == 0) inv = 1'b1;
                ccnt = (ce + 1) % 128;
            end
            if (be > 0) begin
                inv   = 1'b1;
                bleft = be - 1;
            end
        end
        expb = fb ^ inv;
        if (yel_alarm_on && yel_s_bit_sel && !esf_mode && tb_frame == 12) expb = 1'b1;
        step(1'b1, 1'b1, sf, {7'h55 & 7'h0F, fb});
        check(req, {out_fslot, out_data}, {1'b1, 7'h55 & 7'h0F, expb});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        in_valid = 1'b0; in_fslot = 1'b0; in_sf_start = 1'b0; in_data = 8'h00;
        esf_mode = 1'b0; cont_corrupt_en = 1'b0; burst_corrupt_req = 1'b0;
        yel_alarm_on = 1'b0; yel_s_bit_sel = 1'b0; zero_sup_en = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check("R9 reset valid", {7'h0, out_valid}, 8'h00);
        check("R9 reset data", out_data, 8'h00);
        rst_n = 1'b1;
        @(posedge clk);
        #1;

        // R9 / R2: plain superframe passes through
        for (int i = 0; i < 12; i++) fbit_slot(i == 0, i[0], "R9 passthrough");

        // R1: latency and idle behaviour
        step(1'b1, 1'b0, 1'b0, 8'hA5);
        check("R1 valid", {6'h0, out_valid, out_fslot}, 8'h02);
        check("R1 data", out_data, 8'hA5);
        step(1'b0, 1'b0, 1'b0, 8'h77);
        check("R1 idle", {out_valid, out_data[6:0]}, 8'h00);

        // R6 R7 R8: channel byte table
        for (int i = 0; i < 10; i++) begin
            esf_mode      = VEC[i][19];
            yel_alarm_on  = VEC[i][18];
            yel_s_bit_sel = VEC[i][17];
            zero_sup_en   = VEC[i][16];
            step(1'b1, 1'b0, 1'b0, VEC[i][15:8]);
            check("R6/R8 table", out_data, VEC[i][7:0]);
        end
        esf_mode = 1'b0; yel_alarm_on = 1'b0; yel_s_bit_sel = 1'b0; zero_sup_en = 1'b0;

        // R3: continuous corruption across 300 D4 frames
        cont_corrupt_en = 1'b1;
        for (int i = 0; i < 300; i++) fbit_slot(i == 0, 1'b0, "R3 continuous");
        cont_corrupt_en = 1'b0;
        fbit_slot(1'b1, 1'b0, "R3 off");

        // R4: burst in ESF, then a restart mid-burst
        esf_mode = 1'b1;
        burst_corrupt_req = 1'b1;
        for (int i = 0; i < 24; i++) fbit_slot(i == 0, 1'b1, "R4 burst");
        burst_corrupt_req = 1'b0;
        for (int i = 0; i < 4; i++) fbit_slot(1'b0, 1'b1, "R4 idle");
        burst_corrupt_req = 1'b1;
        for (int i = 0; i < 4; i++) fbit_slot(1'b0, 1'b1, "R4 first edge");
        burst_corrupt_req = 1'b0;
        fbit_slot(1'b0, 1'b1, "R4 low");
        burst_corrupt_req = 1'b1;
        for (int i = 0; i < 16; i++) fbit_slot(1'b0, 1'b1, "R4 restart");
        burst_corrupt_req = 1'b0;

        // R5: both modes hit the first eligible bit together
        esf_mode = 1'b0;
        fbit_slot(1'b1, 1'b0, "R5 sync");
        tb_frame = 12; // next sf slot restarts anyway
        cont_corrupt_en = 1'b1;
        burst_corrupt_req = 1'b1;
        for (int i = 0; i < 10; i++) fbit_slot(i == 0, 1'b1, "R5 overlap");
        cont_corrupt_en = 1'b0;
        burst_corrupt_req = 1'b0;

        // R7: S-bit yellow in frame 12
        yel_alarm_on = 1'b1;
        yel_s_bit_sel = 1'b1;
        for (int i = 0; i < 24; i++) fbit_slot(i == 0, 1'b0, "R7 s-bit");
        esf_mode = 1'b1;
        for (int i = 0; i < 24; i++) fbit_slot(i == 0, 1'b0, "R7 esf no alarm");
        yel_alarm_on = 1'b0;
        yel_s_bit_sel = 1'b0;
        esf_mode = 1'b0;

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule